// File: doc/BRIEF.md
# Buck Regulator Run and Protection Sequencer

This block decides, once per clock, whether the power stage of a step-down regulator may switch and how it switches. It merges the hardware enable pin, the voltage-select pin, two software enable bits (one per select level) and a two-bit mode field into a single "enabled" decision and a forced-PWM flag. Around that decision it runs a small sequence: idle, an optional start wait, soft-start, and regulating.

Protection inputs act as already filtered digital flags: input undervoltage, input overvoltage, overtemperature, and a per-switching-cycle current-limit hit strobe. A run of consecutive current-limit cycles puts the power stage into high impedance for a fixed back-off time, and soft-start is then retried. The block also drives the output-discharge switch and assembles the 8-bit status byte read by software. The wait and back-off times are parameters in clock cycles.

Top module: `buck_run_sequencer`

## Requirements
- R1: While `en_pin` is low, `run_switching` is 0 and status bit 0 (buck enabled) is 0. After any disable the sequence restarts from idle.
- R2: With `en_pin` high, `sel_pin` low makes `sw_en0` the gating bit and ignores `sw_en1`. `sel_pin` high makes `sw_en1` the gating bit and ignores `sw_en0`.
- R3: `force_pwm` equals `mode_bits[0]` when `sel_pin` is low and `mode_bits[1]` when `sel_pin` is high. A value of 0 means automatic PFM/PWM.
- R4: When `delay_en` is 1, switching starts exactly `DELAY_CYC`+1 clock edges after the first edge that sees the enable condition true. When `delay_en` is 0, switching starts after 1 edge.
- R5: Soft-start lasts until `ss_done` is sampled high. The regulating state follows, and in it an enabled part with no other flags reports status 8'h81.
- R6: When `LIMIT_RUN` (16) consecutive `cyc_tick` cycles also carry `ilim_hit`, the power stage goes to high impedance on the next edge (`power_stage_hiz`=1, no switching). It stays there for `HICCUP_CYC` cycles and then re-enters soft-start.
- R7: A `cyc_tick` without `ilim_hit`, or any cycle without switching, clears the consecutive current-limit count.
- R8: Any of `uvlo_flag`, `ovp_flag`, `ot_flag` forces `run_switching` to 0 in the same cycle without changing the sequence state. Switching resumes when the flags clear.
- R9: `discharge_on` is 1 exactly when `discharge_en` is 1 and the enable condition (pin and selected software bit) is false.
- R10: The status byte maps bit 7 = power good (regulating and enabled), 6 = undervoltage, 5 = overvoltage, 4 = rising transition (`ramp_up` or soft-start), 3 = falling transition (`ramp_dn`), 2 = register-reset seen (`regs_reset`), 1 = overtemperature, 0 = enabled.
- R11: Removing the enable during back-off leaves high impedance on the next edge and clears the back-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_pin | input | 1 | Hardware enable |
| sel_pin | input | 1 | Voltage-select level |
| sw_en0 | input | 1 | Software enable used when select is low |
| sw_en1 | input | 1 | Software enable used when select is high |
| mode_bits | input | 2 | Forced-PWM request per select level |
| delay_en | input | 1 | Insert start wait before soft-start |
| discharge_en | input | 1 | Allow output discharge when disabled |
| uvlo_flag | input | 1 | Input undervoltage |
| ovp_flag | input | 1 | Input overvoltage |
| ot_flag | input | 1 | Thermal shutdown active |
| cyc_tick | input | 1 | One strobe per switching cycle |
| ilim_hit | input | 1 | Current limit reached in this cycle |
| ss_done | input | 1 | Soft-start ramp complete |
| ramp_up | input | 1 | Rising voltage transition in progress |
| ramp_dn | input | 1 | Falling voltage transition in progress |
| regs_reset | input | 1 | Register reset has been performed |
| run_switching | output | 1 | Power stage allowed to switch |
| force_pwm | output | 1 | Fixed-frequency mode selected |
| power_stage_hiz | output | 1 | Power stage tri-stated (back-off) |
| discharge_on | output | 1 | Output discharge load connected |
| monitor | output | 8 | Status byte |

## Verification
The hardest condition to reach from the ports is the boundary of the current-limit run. Fifteen hits followed by one clean tick must not trip, while the sixteenth consecutive hit must. The stimulus holds `cyc_tick` high and counts edges exactly, so it can drop `ilim_hit` on the cycle where the count has just reached fifteen and then repeat another fifteen-hit run. A full back-off is also reached and then cut short by removing the enable, which exercises the exit from back-off.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_WAIT    = 3'd1,
        SEQ_RAMP    = 3'd2,
        SEQ_RUN     = 3'd3,
        SEQ_BACKOFF = 3'd4
    } seq_state_t;
endpackage

// File: rtl/buck_gate_decode.sv
module buck_gate_decode (
    input  logic       en_pin,
    input  logic       sel_pin,
    input  logic       sw_en0,
    input  logic       sw_en1,
    input  logic [1:0] mode_bits,
    output logic       gate,
    output logic       fpwm
);
    logic chosen_en;

    always_comb begin
        chosen_en = sel_pin ? sw_en1 : sw_en0;
        gate      = en_pin & chosen_en;
        fpwm      = mode_bits[sel_pin];
    end
endmodule

// File: rtl/buck_ilim_counter.sv
module buck_ilim_counter #(
    parameter int LIMIT_RUN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic hit,
    output logic trip
);
    localparam int CNT_W = $clog2(LIMIT_RUN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT_RUN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ilim_t;

    ilim_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        trip = active & tick & hit & (st_q.cnt == LAST);
        if (!active) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (!hit || trip) st_d.cnt = '0;
            else              st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ILIM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R7
    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hit) |=> (st_q.cnt == '0)); // R7
endmodule

// File: rtl/buck_run_sequencer.sv
module buck_run_sequencer
    import buck_seq_pkg::*;
#(
    parameter int DELAY_CYC  = 1000000,
    parameter int HICCUP_CYC = 340000000,
    parameter int LIMIT_RUN  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       sel_pin,
    input  logic       sw_en0,
    input  logic       sw_en1,
    input  logic [1:0] mode_bits,
    input  logic       delay_en,
    input  logic       discharge_en,
    input  logic       uvlo_flag,
    input  logic       ovp_flag,
    input  logic       ot_flag,
    input  logic       cyc_tick,
    input  logic       ilim_hit,
    input  logic       ss_done,
    input  logic       ramp_up,
    input  logic       ramp_dn,
    input  logic       regs_reset,
    output logic       run_switching,
    output logic       force_pwm,
    output logic       power_stage_hiz,
    output logic       discharge_on,
    output logic [7:0] monitor
);
    localparam int TMAX  = (DELAY_CYC > HICCUP_CYC) ? DELAY_CYC : HICCUP_CYC;
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam logic [TMR_W-1:0] WAIT_LAST = TMR_W'(DELAY_CYC - 1);
    localparam logic [TMR_W-1:0] BACK_LAST = TMR_W'(HICCUP_CYC - 1);

    typedef struct packed {
        seq_state_t       state;
        logic [TMR_W-1:0] tmr;
    } seq_t;

    seq_t s_d, s_q;
    logic gate, fpwm, fault, armed, swon, trip;

    buck_gate_decode u_decode (
        .en_pin    (en_pin),
        .sel_pin   (sel_pin),
        .sw_en0    (sw_en0),
        .sw_en1    (sw_en1),
        .mode_bits (mode_bits),
        .gate      (gate),
        .fpwm      (fpwm)
    );

    buck_ilim_counter #(.LIMIT_RUN(LIMIT_RUN)) u_ilim (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (swon),
        .tick   (cyc_tick),
        .hit    (ilim_hit),
        .trip   (trip)
    );

    always_comb begin
        fault = uvlo_flag | ovp_flag | ot_flag;
        armed = (s_q.state == SEQ_RAMP) || (s_q.state == SEQ_RUN);
        swon  = armed & gate & ~fault;

        s_d = s_q;
        if (!gate) begin
            s_d.state = SEQ_IDLE;
        end else begin
            unique case (s_q.state)
                SEQ_IDLE:    s_d.state = delay_en ? SEQ_WAIT : SEQ_RAMP;
                SEQ_WAIT:    if (s_q.tmr == WAIT_LAST) s_d.state = SEQ_RAMP;
                SEQ_RAMP:    if (trip) s_d.state = SEQ_BACKOFF;
                             else if (ss_done) s_d.state = SEQ_RUN;
                SEQ_RUN:     if (trip) s_d.state = SEQ_BACKOFF;
                SEQ_BACKOFF: if (s_q.tmr == BACK_LAST) s_d.state = SEQ_RAMP;
                default:     s_d.state = SEQ_IDLE;
            endcase
        end

        if (s_d.state != s_q.state)
            s_d.tmr = '0;
        else if (s_q.state == SEQ_WAIT || s_q.state == SEQ_BACKOFF)
            s_d.tmr = s_q.tmr + 1'b1;
        else
            s_d.tmr = '0;

        run_switching   = swon;
        force_pwm       = fpwm;
        power_stage_hiz = (s_q.state == SEQ_BACKOFF);
        discharge_on    = discharge_en & ~gate;
        monitor = { (s_q.state == SEQ_RUN) & gate,
                    uvlo_flag,
                    ovp_flag,
                    ramp_up | (s_q.state == SEQ_RAMP),
                    ramp_dn,
                    regs_reset,
                    ot_flag,
                    gate };
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= SEQ_IDLE;
            s_q.tmr   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_OFF_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_pin |-> (!run_switching && !monitor[0])); // R1
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_flag || ovp_flag || ot_flag) |-> !run_switching); // R8
    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        power_stage_hiz |-> !run_switching); // R6
    AST_TRIP_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && gate) |=> power_stage_hiz); // R6
    AST_PGOOD_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(monitor[7]) |-> $past(monitor[4])); // R5
endmodule

// File: tb/tb_buck_run_sequencer.sv
module tb_buck_run_sequencer;
    localparam int D = 6;
    localparam int H = 20;
    localparam int L = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 0, sel_pin = 0, sw_en0 = 0, sw_en1 = 0;
    logic [1:0] mode_bits = 2'b00;
    logic delay_en = 0, discharge_en = 0;
    logic uvlo_flag = 0, ovp_flag = 0, ot_flag = 0;
    logic cyc_tick = 0, ilim_hit = 0, ss_done = 0;
    logic ramp_up = 0, ramp_dn = 0, regs_reset = 0;
    logic run_switching, force_pwm, power_stage_hiz, discharge_on;
    logic [7:0] monitor;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state: 0 idle, 1 wait, 2 ramp, 3 run, 4 backoff
    int m_st = 0;
    int m_tm = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    buck_run_sequencer #(.DELAY_CYC(D), .HICCUP_CYC(H), .LIMIT_RUN(L)) dut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .sel_pin(sel_pin),
        .sw_en0(sw_en0), .sw_en1(sw_en1), .mode_bits(mode_bits),
        .delay_en(delay_en), .discharge_en(discharge_en),
        .uvlo_flag(uvlo_flag), .ovp_flag(ovp_flag), .ot_flag(ot_flag),
        .cyc_tick(cyc_tick), .ilim_hit(ilim_hit), .ss_done(ss_done),
        .ramp_up(ramp_up), .ramp_dn(ramp_dn), .regs_reset(regs_reset),
        .run_switching(run_switching), .force_pwm(force_pwm),
        .power_stage_hiz(power_stage_hiz), .discharge_on(discharge_on),
        .monitor(monitor)
    );

    function automatic bit m_gate();
        return en_pin && (sel_pin ? sw_en1 : sw_en0);
    endfunction

    function automatic bit m_swon();
        return (m_st == 2 || m_st == 3) && m_gate() && !(uvlo_flag || ovp_flag || ot_flag);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_tm = 0; m_cnt = 0;
        end else begin
            int nst;
            bit trip;
            trip = m_swon() && cyc_tick && ilim_hit && (m_cnt == L - 1);
            if (!m_swon()) m_cnt = 0;
            else if (cyc_tick) m_cnt = (ilim_hit && !trip) ? m_cnt + 1 : 0;
            nst = m_st;
            if (!m_gate()) nst = 0;
            else if (m_st == 0) nst = delay_en ? 1 : 2;
            else if (m_st == 1) begin if (m_tm == D - 1) nst = 2; end
            else if (m_st == 2) begin if (trip) nst = 4; else if (ss_done) nst = 3; end
            else if (m_st == 3) begin if (trip) nst = 4; end
            else if (m_st == 4) begin if (m_tm == H - 1) nst = 2; end
            if (nst != m_st) m_tm = 0;
            else if (m_st == 1 || m_st == 4) m_tm = m_tm + 1;
            else m_tm = 0;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [11:0] e, a;
            e[11] = m_swon();
            e[10] = sel_pin ? mode_bits[1] : mode_bits[0];
            e[9]  = (m_st == 4);
            e[8]  = discharge_en && !m_gate();
            e[7]  = (m_st == 3) && m_gate();
            e[6]  = uvlo_flag;
            e[5]  = ovp_flag;
            e[4]  = ramp_up || (m_st == 2);
            e[3]  = ramp_dn;
            e[2]  = regs_reset;
            e[1]  = ot_flag;
            e[0]  = m_gate();
            a = {run_switching, force_pwm, power_stage_hiz, discharge_on, monitor};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s cycle compare: actual %h expected %h", cur_req, a, e);
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic adv(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        adv(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", monitor, 8'h00);
        chk("R1", {7'd0, run_switching}, 8'd0);

        // R4 no-delay start, R3 auto mode with select low
        adv(1);
        cur_req = "R4";
        en_pin = 1; sw_en0 = 1; mode_bits = 2'b10; discharge_en = 1; cyc_tick = 1;
        @(negedge clk);
        chk("R4", {7'd0, run_switching}, 8'd0);
        chk("R9", {7'd0, discharge_on}, 8'd0);
        adv(1);
        @(negedge clk);
        chk("R4", {7'd0, run_switching}, 8'd1);
        chk("R10", monitor, 8'h11);
        chk("R3", {7'd0, force_pwm}, 8'd0);

        // R5 regulating status
        adv(1);
        cur_req = "R5";
        ss_done = 1;
        adv(1);
        @(negedge clk);
        chk("R5", monitor, 8'h81);

        // R2 select high uses sw_en1
        adv(1);
        cur_req = "R2";
        sel_pin = 1;
        @(negedge clk);
        chk("R2", {7'd0, run_switching}, 8'd0);
        chk("R9", {7'd0, discharge_on}, 8'd1);
        chk("R2", monitor, 8'h00);
        adv(1);
        sw_en1 = 1;
        @(negedge clk);
        chk("R3", {7'd0, force_pwm}, 8'd1);
        adv(3);
        sw_en0 = 0;
        @(negedge clk);
        chk("R2", {7'd0, run_switching}, 8'd1);

        // R3 select low with mode bit 0 set
        adv(1);
        cur_req = "R3";
        sw_en0 = 1; sel_pin = 0; mode_bits = 2'b01;
        @(negedge clk);
        chk("R3", {7'd0, force_pwm}, 8'd1);

        // R4 start wait, R1 restart after disable
        adv(1);
        cur_req = "R4";
        en_pin = 0; delay_en = 1;
        @(negedge clk);
        chk("R1", {7'd0, monitor[0]}, 8'd0);
        adv(1);
        en_pin = 1;
        adv(D);
        @(negedge clk);
        chk("R4", {7'd0, run_switching}, 8'd0);
        adv(1);
        @(negedge clk);
        chk("R4", {7'd0, run_switching}, 8'd1);
        adv(2);

        // R6 back-off after a full run of limit hits
        cur_req = "R6";
        ilim_hit = 1;
        adv(L - 1);
        @(negedge clk);
        chk("R6", {7'd0, power_stage_hiz}, 8'd0);
        adv(1);
        ilim_hit = 0;
        @(negedge clk);
        chk("R6", {6'd0, power_stage_hiz, run_switching}, 8'd2);
        chk("R6", monitor, 8'h01);
        adv(H - 1);
        @(negedge clk);
        chk("R6", {7'd0, power_stage_hiz}, 8'd1);
        adv(1);
        @(negedge clk);
        chk("R6", {6'd0, power_stage_hiz, run_switching}, 8'd1);
        adv(2);

        // R7 clean tick breaks the run
        cur_req = "R7";
        ilim_hit = 1;
        adv(L - 1);
        ilim_hit = 0;
        adv(1);
        ilim_hit = 1;
        adv(L - 1);
        ilim_hit = 0;
        @(negedge clk);
        chk("R7", {6'd0, power_stage_hiz, run_switching}, 8'd1);
        adv(2);

        // R8 faults gate switching only
        cur_req = "R8";
        uvlo_flag = 1;
        @(negedge clk);
        chk("R8", {7'd0, run_switching}, 8'd0);
        chk("R10", monitor, 8'hC1);
        adv(1);
        uvlo_flag = 0; ot_flag = 1;
        @(negedge clk);
        chk("R8", monitor, 8'h83);
        adv(1);
        ot_flag = 0; ovp_flag = 1;
        @(negedge clk);
        chk("R10", monitor, 8'hA1);
        adv(1);
        ovp_flag = 0;
        @(negedge clk);
        chk("R8", {7'd0, run_switching}, 8'd1);

        // R10 status passthrough bits
        adv(1);
        cur_req = "R10";
        ramp_dn = 1; regs_reset = 1;
        @(negedge clk);
        chk("R10", monitor, 8'h8D);
        adv(1);
        ramp_up = 1;
        @(negedge clk);
        chk("R10", monitor, 8'h9D);
        adv(1);
        ramp_up = 0; ramp_dn = 0; regs_reset = 0;

        // R11 disable during back-off
        cur_req = "R11";
        ilim_hit = 1;
        adv(L);
        ilim_hit = 0;
        adv(3);
        @(negedge clk);
        chk("R11", {7'd0, power_stage_hiz}, 8'd1);
        adv(1);
        en_pin = 0; discharge_en = 0;
        adv(1);
        @(negedge clk);
        chk("R11", {7'd0, power_stage_hiz}, 8'd0);
        chk("R9", {7'd0, discharge_on}, 8'd0);
        adv(1);
        en_pin = 1;
        adv(D + 4);
        @(negedge clk);
        chk("R11", monitor, 8'h81);

        adv(2);
        finish_run();
    end
endmodule